// File: doc/BRIEF.md
# Console Button Hold-Time Command Decoder

This block turns three synchronised console button levels into one-cycle command pulses for a power controller. The buttons request power-on, power-off and emergency-off. Each level first passes a debounce filter that counts ticks of a slow timing enable. A rising edge of the filtered power-on or emergency-off level gives its command pulse at once, with no hold qualification.

The power-off button carries two commands. While its filtered level stays high, a hold counter advances on every tick. An orderly power-off pulse fires when the hold reaches the orderly threshold. A forced power-off pulse fires when the hold goes beyond the forced threshold. Releasing the button earlier gives nothing and clears the counter. All thresholds are parameters counted in ticks. With a one-millisecond tick the defaults give 20 ms, 3 s and more than 10 s. A bench can scale them down.

Top module: `btn_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released with no button pressed, all four command outputs stay low.
- R2: A filtered button level changes only after the raw level has differed from it on DEBOUNCE_TICKS consecutive tick cycles. A shorter excursion has no effect, and the filtered level never changes on a cycle without a tick.
- R3: A press of the power-on button gives one `cmd_power_on` pulse. It appears on the clock edge that samples the DEBOUNCE_TICKS-th tick of the press.
- R4: A press of the emergency-off button gives one `cmd_emergency` pulse with the same timing as R3. No hold time is required.
- R5: While the filtered power-off level stays high, `cmd_power_off` pulses once, on the edge that samples the ORDERLY_TICKS-th tick of the hold.
- R6: If the hold continues, `cmd_forced_off` pulses once, on the edge that samples tick FORCED_TICKS+1 of the hold. This means the hold has strictly exceeded FORCED_TICKS.
- R7: If the filtered power-off level falls before ORDERLY_TICKS hold ticks, no command is produced. The hold count restarts from zero on the next press.
- R8: Every command is exactly one clock cycle wide and fires at most once per press, however long the button is held. `cmd_power_off` and `cmd_forced_off` are never high in the same cycle (ORDERLY_TICKS < FORCED_TICKS).
- R9: Hold time advances only on cycles with `tick` high. Cycles without a tick never move a command nearer to firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timing enable, one cycle high per time unit (1 ms) |
| btn_on_raw | input | 1 | Synchronised power-on button level, high when pressed |
| btn_off_raw | input | 1 | Synchronised power-off button level, high when pressed |
| btn_emg_raw | input | 1 | Synchronised emergency-off button level, high when pressed |
| cmd_power_on | output | 1 | One-cycle power-on command |
| cmd_power_off | output | 1 | One-cycle orderly power-off command |
| cmd_forced_off | output | 1 | One-cycle forced power-off command |
| cmd_emergency | output | 1 | One-cycle emergency-off command |

## Verification
The power-off button is driven with four hold patterns:
- a hold released just short of the orderly mark, which must stay silent and must not leave a residue for the next press;
- a hold released between the two marks, which must give the orderly command alone;
- a hold kept well past the forced mark, which must give orderly then forced exactly once each;
- a hold during which the tick is stopped for a long stretch, which separates tick counting from cycle counting.

Short bounces shorter than the filter length show whether debouncing is applied. Long power-on and emergency presses show edge-only behaviour.

Each expected pulse carries the exact tick count at which it must appear. Any early, late, repeated or stray pulse is therefore caught.

// File: rtl/btn_cmd_pkg.sv
package btn_cmd_pkg;

    localparam int NUM_BTN = 3;

    typedef enum int {
        BTN_ON  = 0,
        BTN_OFF = 1,
        BTN_EMG = 2
    } btn_idx_e;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int DEBOUNCE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic level,
    output logic rise
);

    localparam int CNT_W = $clog2(DEBOUNCE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_TICKS - 1);

    typedef struct packed {
        logic             level;
        logic             rise;
        logic [CNT_W-1:0] cnt;
    } deb_state_t;

    deb_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        if (raw == s_q.level) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.cnt == LAST) begin
                s_d.level = raw;
                s_d.rise  = raw;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.level;
    assign rise  = s_q.rise;

endmodule

// File: rtl/hold_classifier.sv
module hold_classifier #(
    parameter int ORDERLY_TICKS = 3000,
    parameter int FORCED_TICKS  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic held,
    output logic orderly,
    output logic forced
);

    localparam int CNT_W = $clog2(FORCED_TICKS + 2);
    localparam logic [CNT_W-1:0] ORD_AT = CNT_W'(ORDERLY_TICKS - 1);
    localparam logic [CNT_W-1:0] FRC_AT = CNT_W'(FORCED_TICKS);
    localparam logic [CNT_W-1:0] SAT    = CNT_W'(FORCED_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             orderly;
        logic             forced;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.orderly = 1'b0;
        s_d.forced  = 1'b0;
        if (!held) begin
            s_d.cnt = '0;
        end else if (tick && (s_q.cnt != SAT)) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == ORD_AT) begin
                s_d.orderly = 1'b1;
            end
            if (s_q.cnt == FRC_AT) begin
                s_d.forced = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign orderly = s_q.orderly;
    assign forced  = s_q.forced;

endmodule

// File: rtl/btn_cmd_decoder.sv
module btn_cmd_decoder
    import btn_cmd_pkg::*;
#(
    parameter int DEBOUNCE_TICKS = 20,
    parameter int ORDERLY_TICKS  = 3000,
    parameter int FORCED_TICKS   = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_on_raw,
    input  logic btn_off_raw,
    input  logic btn_emg_raw,
    output logic cmd_power_on,
    output logic cmd_power_off,
    output logic cmd_forced_off,
    output logic cmd_emergency
);

    logic [NUM_BTN-1:0] btn_raw;
    logic [NUM_BTN-1:0] btn_level;
    logic [NUM_BTN-1:0] btn_rise;

    assign btn_raw[BTN_ON]  = btn_on_raw;
    assign btn_raw[BTN_OFF] = btn_off_raw;
    assign btn_raw[BTN_EMG] = btn_emg_raw;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_deb
        btn_debounce #(
            .DEBOUNCE_TICKS(DEBOUNCE_TICKS)
        ) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .raw  (btn_raw[i]),
            .level(btn_level[i]),
            .rise (btn_rise[i])
        );
    end

    hold_classifier #(
        .ORDERLY_TICKS(ORDERLY_TICKS),
        .FORCED_TICKS (FORCED_TICKS)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .held   (btn_level[BTN_OFF]),
        .orderly(cmd_power_off),
        .forced (cmd_forced_off)
    );

    assign cmd_power_on  = btn_rise[BTN_ON];
    assign cmd_emergency = btn_rise[BTN_EMG];

endmodule

// File: rtl/btn_cmd_decoder_chk.sv
module btn_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [2:0] btn_level,
    input logic [2:0] btn_rise,
    input logic       cmd_power_on,
    input logic       cmd_power_off,
    input logic       cmd_forced_off,
    input logic       cmd_emergency
);

    AST_ON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_power_on |=> !cmd_power_on); // R8
    AST_EMG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_emergency |=> !cmd_emergency); // R8
    AST_OFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_power_off |=> !cmd_power_off); // R8
    AST_OFF_FORCED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_power_off && cmd_forced_off)); // R8
    AST_ON_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_power_on |-> (btn_level[0] && !$past(btn_level[0]))); // R3
    AST_EMG_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_emergency |-> (btn_level[2] && !$past(btn_level[2]))); // R4
    AST_OFF_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_power_off |-> $past(btn_level[1])); // R5
    AST_FORCED_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_forced_off |-> $past(btn_level[1])); // R6
    AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(btn_level) |-> $past(tick)); // R2
    AST_HOLD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_power_off || cmd_forced_off) |-> $past(tick)); // R9
    AST_RISE_IS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise[1] |-> btn_level[1]); // R2

endmodule

bind btn_cmd_decoder btn_cmd_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .btn_level     (btn_level),
    .btn_rise      (btn_rise),
    .cmd_power_on  (cmd_power_on),
    .cmd_power_off (cmd_power_off),
    .cmd_forced_off(cmd_forced_off),
    .cmd_emergency (cmd_emergency)
);

// File: tb/btn_cmd_decoder_tb.sv
module btn_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int ORD        = 10;
    localparam int FRC        = 20;
    localparam int TICK_DIV   = 3;
    localparam int WATCHDOG   = 100000;

    localparam int K_ON  = 0;
    localparam int K_OFF = 1;
    localparam int K_FRC = 2;
    localparam int K_EMG = 3;

    typedef struct {
        int     kind;
        longint at_tick;
        string  req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tick_run = 1'b1;
    logic btn_on_raw = 1'b0;
    logic btn_off_raw = 1'b0;
    logic btn_emg_raw = 1'b0;
    logic cmd_power_on, cmd_power_off, cmd_forced_off, cmd_emergency;

    int     checks = 0;
    int     fails = 0;
    longint tick_cnt = 0;
    int     div_cnt = 0;
    int     cycles = 0;
    bit     done = 1'b0;
    exp_t   exp_q[$];

    btn_cmd_decoder #(
        .DEBOUNCE_TICKS(DEB),
        .ORDERLY_TICKS (ORD),
        .FORCED_TICKS  (FRC)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .btn_on_raw    (btn_on_raw),
        .btn_off_raw   (btn_off_raw),
        .btn_emg_raw   (btn_emg_raw),
        .cmd_power_on  (cmd_power_on),
        .cmd_power_off (cmd_power_off),
        .cmd_forced_off(cmd_forced_off),
        .cmd_emergency (cmd_emergency)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        tick    <= tick_run && (div_cnt == 0);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (tick) tick_cnt <= tick_cnt + 1;
    end

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic push_exp(int kind, longint at_tick, string req);
        exp_t e;
        e.kind = kind;
        e.at_tick = at_tick;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic seen(int kind);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected pulse: actual kind %0d at tick %0d, expected no pulse", kind, tick_cnt);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at_tick != tick_cnt) begin
                fails++;
                $display("FAIL %s: actual kind %0d at tick %0d, expected kind %0d at tick %0d",
                         e.req, kind, tick_cnt, e.kind, e.at_tick);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmd_power_on)   seen(K_ON);
            if (cmd_power_off)  seen(K_OFF);
            if (cmd_forced_off) seen(K_FRC);
            if (cmd_emergency)  seen(K_EMG);
        end
    end

    always @(negedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            summary_and_end();
        end
    end

    task automatic wait_ticks(int n);
        longint target;
        target = tick_cnt + n;
        while (tick_cnt < target) @(negedge clk);
    endtask

    task automatic expect_drained(string req);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d pulses still missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic check_zero(string name, logic v);
        checks++;
        if (v !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s after reset: actual %b, expected 0", name, v);
        end
    endtask

    initial begin
        longint t0;
        repeat (5) @(negedge clk);
        check_zero("cmd_power_on", cmd_power_on);
        check_zero("cmd_power_off", cmd_power_off);
        check_zero("cmd_forced_off", cmd_forced_off);
        check_zero("cmd_emergency", cmd_emergency);
        rst_n = 1'b1;
        wait_ticks(10);
        expect_drained("R1 idle");

        // R3 and R8: long power-on press gives one pulse
        t0 = tick_cnt;
        push_exp(K_ON, t0 + DEB, "R3");
        btn_on_raw = 1'b1;
        wait_ticks(40);
        btn_on_raw = 1'b0;
        wait_ticks(DEB + 3);
        expect_drained("R3");

        // R4: emergency press, no hold qualification
        t0 = tick_cnt;
        push_exp(K_EMG, t0 + DEB, "R4");
        btn_emg_raw = 1'b1;
        wait_ticks(DEB + 30);
        btn_emg_raw = 1'b0;
        wait_ticks(DEB + 3);
        expect_drained("R4");

        // R2: bounces shorter than the filter are dropped
        for (int i = 0; i < 3; i++) begin
            btn_on_raw = 1'b1;
            btn_emg_raw = 1'b1;
            btn_off_raw = 1'b1;
            wait_ticks(DEB - 1);
            btn_on_raw = 1'b0;
            btn_emg_raw = 1'b0;
            btn_off_raw = 1'b0;
            wait_ticks(2);
        end
        wait_ticks(DEB + 3);
        expect_drained("R2");

        // R7: release before orderly mark, then full press times from zero
        btn_off_raw = 1'b1;
        wait_ticks(ORD - 2);
        btn_off_raw = 1'b0;
        wait_ticks(DEB + 3);
        expect_drained("R7 short hold");
        t0 = tick_cnt;
        push_exp(K_OFF, t0 + DEB + ORD, "R7");
        btn_off_raw = 1'b1;
        wait_ticks(DEB + ORD + 1);
        btn_off_raw = 1'b0;
        wait_ticks(DEB + FRC);
        expect_drained("R5 orderly only");

        // R5, R6, R8: hold well past the forced mark
        t0 = tick_cnt;
        push_exp(K_OFF, t0 + DEB + ORD, "R5");
        push_exp(K_FRC, t0 + DEB + FRC + 1, "R6");
        btn_off_raw = 1'b1;
        wait_ticks(DEB + FRC + 30);
        btn_off_raw = 1'b0;
        wait_ticks(DEB + 3);
        expect_drained("R6");

        // R9: tick stopped mid-hold delays the command in cycles, not in ticks
        t0 = tick_cnt;
        push_exp(K_OFF, t0 + DEB + ORD, "R9");
        btn_off_raw = 1'b1;
        wait_ticks(DEB + ORD - 2);
        tick_run = 1'b0;
        repeat (200) @(negedge clk);
        tick_run = 1'b1;
        wait_ticks(5);
        btn_off_raw = 1'b0;
        wait_ticks(DEB + 3);
        expect_drained("R9");

        done = 1'b1;
        summary_and_end();
    end

endmodule